// File: doc/BRIEF.md
# Burst Block-Copy DMA Engine

This block copies a run of 32-bit words from one memory region to another with no processor help once it has been started. Software programs a source byte address, a destination byte address and a word count through a small register port, then sets a go bit. The engine asks an external arbiter for the shared bus. It reads up to four words into a local buffer with one burst, gives the bus back, asks again, and writes those words out with a second burst. It repeats this until the count is used up.

Every burst carries one address and a beat count, followed by that many data beats. Each beat is paced by the memory's acknowledge. A single level interrupt reports either the end of the whole block or an abort. The abort happens when the count is zero or when the memory flags a bus error on any beat. The interrupt stays high until software clears the cause in the status register.

Top module: `burst_dma`

## Requirements
- R1: After reset every register reads zero, and `irq` and `bus_req` are low. The register byte offsets are: 0x00 source address, 0x04 destination address, 0x08 word count (16 bits), 0x0C control and 0x10 status. In control, bit0 is go (reads 0) and bit1 is interrupt enable. In status, bit0 is busy, bit1 is done and bit2 is error. Registers read back what was written.
- R2: Writing control with bit0 set while idle and with a non-zero count makes busy read 1 and raises `bus_req` in the next cycle.
- R3: A burst command (`mem_cmd_valid`) lasts exactly one cycle. It is issued only while `bus_req` and `bus_gnt` are both high. During a write burst `mem_wvalid` is high on every beat.
- R4: The count is split into chunks of min(4, words left). For each chunk there is a read burst at source + 4·(words done), then a write burst of the same length at destination + 4·(words done). `mem_cmd_write` is 1 for writes.
- R5: Write beat k of a chunk carries the data returned by read beat k of that chunk, so the destination ends up equal to the source.
- R6: After the last beat of each burst, `bus_req` is low for at least one cycle before the next burst command.
- R7: The acknowledge of the final write beat clears busy, sets done and leaves `bus_req` low.
- R8: A `mem_berr` with an acknowledge on any beat stops the transfer. That beat is not written, busy clears, error sets, and no further burst is issued.
- R9: Go with a count of zero sets error and starts no bus activity.
- R10: `irq` equals enable AND (done OR error). It stays high until a register write clears the cause.
- R11: While busy, writes to the address, count and control registers are ignored, including a second go.
- R12: Writing status with bit1 or bit2 set clears done or error. An accepted go clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Level interrupt |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_cmd_valid | output | 1 | Burst command, one cycle |
| mem_cmd_write | output | 1 | 1 = write burst, 0 = read burst |
| mem_cmd_addr | output | 32 | Byte address of the first beat |
| mem_cmd_beats | output | 3 | Number of beats in the burst (1..4) |
| mem_wvalid | output | 1 | Write beat data valid |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read beat data, valid with mem_ack |
| mem_ack | input | 1 | Beat accepted or returned |
| mem_berr | input | 1 | Bus error on the acknowledged beat |

## Verification
The properties assume an arbiter that, once it grants, keeps the grant until the request drops. They also assume the memory gives no acknowledge outside a burst's data phase, and no more acknowledges than the commanded beat count. The bench arbiter grants after a random wait of zero to two cycles, keeps the grant while the request stays high, and withdraws it as soon as the request falls. The bench memory acknowledges only the beats of a burst it has seen commanded, with random idle gaps between beats. It raises the error flag on one chosen beat in a single scenario.

// File: rtl/burst_dma_pkg.sv
package burst_dma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_CMD,
        ST_RD_DATA,
        ST_WR_REL,
        ST_WR_REQ,
        ST_WR_CMD,
        ST_WR_DATA,
        ST_RD_REL
    } eng_state_e;

    localparam logic [4:0] OFS_SRC  = 5'h00;
    localparam logic [4:0] OFS_DST  = 5'h04;
    localparam logic [4:0] OFS_LEN  = 5'h08;
    localparam logic [4:0] OFS_CTRL = 5'h0C;
    localparam logic [4:0] OFS_STAT = 5'h10;

    localparam int CTRL_GO   = 0;
    localparam int CTRL_IE   = 1;
    localparam int STAT_BUSY = 0;
    localparam int STAT_DONE = 1;
    localparam int STAT_ERR  = 2;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import burst_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [4:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          eng_busy,
    input  logic          eng_ok,
    input  logic          eng_err,
    output logic [AW-1:0] cfg_src,
    output logic [AW-1:0] cfg_dst,
    output logic [LW-1:0] cfg_len,
    output logic          go,
    output logic          irq
);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] len;
        logic          ie;
        logic          done;
        logic          err;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        go    = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                OFS_SRC:  if (!eng_busy) cfg_d.src = reg_wdata[AW-1:0];
                OFS_DST:  if (!eng_busy) cfg_d.dst = reg_wdata[AW-1:0];
                OFS_LEN:  if (!eng_busy) cfg_d.len = reg_wdata[LW-1:0];
                OFS_CTRL: begin
                    if (!eng_busy) begin
                        cfg_d.ie = reg_wdata[CTRL_IE];
                        if (reg_wdata[CTRL_GO]) begin
                            cfg_d.done = 1'b0;
                            cfg_d.err  = 1'b0;
                            if (cfg_q.len == '0) cfg_d.err = 1'b1;
                            else                 go        = 1'b1;
                        end
                    end
                end
                OFS_STAT: begin
                    if (reg_wdata[STAT_DONE]) cfg_d.done = 1'b0;
                    if (reg_wdata[STAT_ERR])  cfg_d.err  = 1'b0;
                end
                default: ;
            endcase
        end
        if (eng_ok)  cfg_d.done = 1'b1;
        if (eng_err) cfg_d.err  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_SRC:  reg_rdata[AW-1:0] = cfg_q.src;
            OFS_DST:  reg_rdata[AW-1:0] = cfg_q.dst;
            OFS_LEN:  reg_rdata[LW-1:0] = cfg_q.len;
            OFS_CTRL: reg_rdata[CTRL_IE] = cfg_q.ie;
            OFS_STAT: begin
                reg_rdata[STAT_BUSY] = eng_busy;
                reg_rdata[STAT_DONE] = cfg_q.done;
                reg_rdata[STAT_ERR]  = cfg_q.err;
            end
            default: ;
        endcase
    end

    assign cfg_src = cfg_q.src;
    assign cfg_dst = cfg_q.dst;
    assign cfg_len = cfg_q.len;
    assign irq     = cfg_q.ie & (cfg_q.done | cfg_q.err);

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import burst_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LW    = 16,
    parameter int BURST = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go,
    input  logic [AW-1:0]                 cfg_src,
    input  logic [AW-1:0]                 cfg_dst,
    input  logic [LW-1:0]                 cfg_len,
    output logic                          busy,
    output logic                          fin_ok,
    output logic                          fin_err,
    output logic                          bus_req,
    input  logic                          bus_gnt,
    output logic                          mem_cmd_valid,
    output logic                          mem_cmd_write,
    output logic [AW-1:0]                 mem_cmd_addr,
    output logic [$clog2(BURST+1)-1:0]    mem_cmd_beats,
    output logic                          mem_wvalid,
    output logic [DW-1:0]                 mem_wdata,
    input  logic [DW-1:0]                 mem_rdata,
    input  logic                          mem_ack,
    input  logic                          mem_berr
);

    localparam int BW = $clog2(BURST + 1);
    localparam int IW = (BURST > 1) ? $clog2(BURST) : 1;

    typedef struct packed {
        eng_state_e                st;
        logic [AW-1:0]             rd_addr;
        logic [AW-1:0]             wr_addr;
        logic [LW-1:0]             remain;
        logic [BW-1:0]             beats;
        logic [IW-1:0]             idx;
        logic [BURST-1:0][DW-1:0]  buffer;
    } eng_t;

    eng_t eng_d, eng_q;
    logic last_beat;

    function automatic logic [BW-1:0] chunk_of(input logic [LW-1:0] words);
        if (words >= LW'(BURST)) return BW'(BURST);
        else                     return BW'(words);
    endfunction

    assign last_beat = ((BW'(eng_q.idx) + BW'(1)) == eng_q.beats);

    always_comb begin
        eng_d   = eng_q;
        fin_ok  = 1'b0;
        fin_err = 1'b0;
        case (eng_q.st)
            ST_IDLE: begin
                if (go) begin
                    eng_d.rd_addr = cfg_src;
                    eng_d.wr_addr = cfg_dst;
                    eng_d.remain  = cfg_len;
                    eng_d.beats   = chunk_of(cfg_len);
                    eng_d.st      = ST_RD_REQ;
                end
            end
            ST_RD_REQ: if (bus_gnt) eng_d.st = ST_RD_CMD;
            ST_RD_CMD: begin
                eng_d.idx = '0;
                eng_d.st  = ST_RD_DATA;
            end
            ST_RD_DATA: begin
                if (mem_ack) begin
                    if (mem_berr) begin
                        fin_err  = 1'b1;
                        eng_d.st = ST_IDLE;
                    end else begin
                        eng_d.buffer[eng_q.idx] = mem_rdata;
                        eng_d.idx = eng_q.idx + IW'(1);
                        if (last_beat) begin
                            eng_d.rd_addr = eng_q.rd_addr + (AW'(eng_q.beats) << 2);
                            eng_d.st      = ST_WR_REL;
                        end
                    end
                end
            end
            ST_WR_REL: eng_d.st = ST_WR_REQ;
            ST_WR_REQ: if (bus_gnt) eng_d.st = ST_WR_CMD;
            ST_WR_CMD: begin
                eng_d.idx = '0;
                eng_d.st  = ST_WR_DATA;
            end
            ST_WR_DATA: begin
                if (mem_ack) begin
                    if (mem_berr) begin
                        fin_err  = 1'b1;
                        eng_d.st = ST_IDLE;
                    end else begin
                        eng_d.idx = eng_q.idx + IW'(1);
                        if (last_beat) begin
                            eng_d.wr_addr = eng_q.wr_addr + (AW'(eng_q.beats) << 2);
                            eng_d.remain  = eng_q.remain - LW'(eng_q.beats);
                            eng_d.beats   = chunk_of(eng_q.remain - LW'(eng_q.beats));
                            if (eng_q.remain == LW'(eng_q.beats)) begin
                                fin_ok   = 1'b1;
                                eng_d.st = ST_IDLE;
                            end else begin
                                eng_d.st = ST_RD_REL;
                            end
                        end
                    end
                end
            end
            ST_RD_REL: eng_d.st = ST_RD_REQ;
            default:   eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    always_comb begin
        busy = (eng_q.st != ST_IDLE);
        case (eng_q.st)
            ST_RD_REQ, ST_RD_CMD, ST_RD_DATA,
            ST_WR_REQ, ST_WR_CMD, ST_WR_DATA: bus_req = 1'b1;
            default:                           bus_req = 1'b0;
        endcase
        mem_cmd_valid = (eng_q.st == ST_RD_CMD) || (eng_q.st == ST_WR_CMD);
        mem_cmd_write = (eng_q.st == ST_WR_CMD);
        mem_cmd_addr  = (eng_q.st == ST_WR_CMD) ? eng_q.wr_addr : eng_q.rd_addr;
        mem_cmd_beats = eng_q.beats;
        mem_wvalid    = (eng_q.st == ST_WR_DATA);
        mem_wdata     = eng_q.buffer[eng_q.idx];
    end

endmodule

// File: rtl/burst_dma.sv
module burst_dma
    import burst_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LW    = 16,
    parameter int BURST = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [4:0]                  reg_addr,
    input  logic [DW-1:0]               reg_wdata,
    output logic [DW-1:0]               reg_rdata,
    output logic                        irq,
    output logic                        bus_req,
    input  logic                        bus_gnt,
    output logic                        mem_cmd_valid,
    output logic                        mem_cmd_write,
    output logic [AW-1:0]               mem_cmd_addr,
    output logic [$clog2(BURST+1)-1:0]  mem_cmd_beats,
    output logic                        mem_wvalid,
    output logic [DW-1:0]               mem_wdata,
    input  logic [DW-1:0]               mem_rdata,
    input  logic                        mem_ack,
    input  logic                        mem_berr
);

    logic [AW-1:0] cfg_src;
    logic [AW-1:0] cfg_dst;
    logic [LW-1:0] cfg_len;
    logic          go;
    logic          eng_busy;
    logic          eng_ok;
    logic          eng_err;

    dma_cfg_regs #(.AW(AW), .DW(DW), .LW(LW)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .eng_busy  (eng_busy),
        .eng_ok    (eng_ok),
        .eng_err   (eng_err),
        .cfg_src   (cfg_src),
        .cfg_dst   (cfg_dst),
        .cfg_len   (cfg_len),
        .go        (go),
        .irq       (irq)
    );

    dma_xfer_engine #(.AW(AW), .DW(DW), .LW(LW), .BURST(BURST)) i_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (go),
        .cfg_src       (cfg_src),
        .cfg_dst       (cfg_dst),
        .cfg_len       (cfg_len),
        .busy          (eng_busy),
        .fin_ok        (eng_ok),
        .fin_err       (eng_err),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .mem_cmd_valid (mem_cmd_valid),
        .mem_cmd_write (mem_cmd_write),
        .mem_cmd_addr  (mem_cmd_addr),
        .mem_cmd_beats (mem_cmd_beats),
        .mem_wvalid    (mem_wvalid),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_ack       (mem_ack),
        .mem_berr      (mem_berr)
    );

endmodule

// File: rtl/burst_dma_chk.sv
module burst_dma_chk #(
    parameter int AW    = 32,
    parameter int LW    = 16,
    parameter int BURST = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_we,
    input logic                        irq,
    input logic                        bus_req,
    input logic                        bus_gnt,
    input logic                        mem_cmd_valid,
    input logic [$clog2(BURST+1)-1:0]  mem_cmd_beats,
    input logic                        eng_busy,
    input logic [AW-1:0]               cfg_src,
    input logic [AW-1:0]               cfg_dst,
    input logic [LW-1:0]               cfg_len
);

    a_r3_cmd_granted: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> (bus_req && bus_gnt));

    a_r3_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |=> !mem_cmd_valid);

    a_r4_beats_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> (mem_cmd_beats != '0 && int'(mem_cmd_beats) <= BURST));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> (!bus_req && !mem_cmd_valid));

    a_r10_irq_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_we));

    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && $past(eng_busy)) |-> ($stable(cfg_len) && $stable(cfg_src) && $stable(cfg_dst)));

endmodule

bind burst_dma burst_dma_chk #(.AW(AW), .LW(LW), .BURST(BURST)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .irq           (irq),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .mem_cmd_valid (mem_cmd_valid),
    .mem_cmd_beats (mem_cmd_beats),
    .eng_busy      (eng_busy),
    .cfg_src       (cfg_src),
    .cfg_dst       (cfg_dst),
    .cfg_len       (cfg_len)
);

// File: tb/test_burst_dma.sv
module test_burst_dma;

    localparam logic [4:0] A_SRC = 5'h00, A_DST = 5'h04, A_LEN = 5'h08,
                           A_CTL = 5'h0C, A_STA = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        irq, bus_req, bus_gnt;
    logic        mem_cmd_valid, mem_cmd_write, mem_wvalid;
    logic [31:0] mem_cmd_addr, mem_wdata, mem_rdata;
    logic [2:0]  mem_cmd_beats;
    logic        mem_ack, mem_berr;

    always #2 clk = ~clk;

    burst_dma i_burst_dma (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_cmd_valid(mem_cmd_valid),
        .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
        .mem_cmd_beats(mem_cmd_beats), .mem_wvalid(mem_wvalid),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_berr(mem_berr)
    );

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // reference model state
    typedef struct { bit wr; int unsigned addr; int unsigned n; int unsigned from; } cmd_t;
    cmd_t exp_q[$];
    int unsigned memw[int unsigned];
    bit m_busy = 0, m_done = 0, m_err = 0, m_ie = 0;
    int unsigned s_src = 0, s_dst = 0, s_len = 0;
    int err_at = -1;
    int beat_total = 0;

    function automatic int unsigned pat(input int unsigned a);
        return (a * 32'h9E37) ^ 32'h5A5A_0000;
    endfunction

    function automatic int unsigned mem_rd(input int unsigned a);
        if (memw.exists(a)) return memw[a];
        return pat(a);
    endfunction

    // arbiter: grants after 0..2 cycles, holds while requested
    int gnt_wait = 0;
    always @(negedge clk) begin
        if (!rst_n || !bus_req) begin
            bus_gnt  <= 1'b0;
            gnt_wait = int'($urandom % 3);
        end else if (gnt_wait == 0) begin
            bus_gnt <= 1'b1;
        end else begin
            gnt_wait--;
        end
    end

    // memory: follows commanded bursts, random gaps, optional error
    bit    in_burst = 0, need_drop = 0;
    cmd_t  cur;
    int    beat = 0;
    always @(negedge clk) begin
        mem_ack   <= 1'b0;
        mem_berr  <= 1'b0;
        mem_rdata <= '0;
        if (rst_n) begin
            if (!bus_req) need_drop = 0;
            if (mem_cmd_valid) begin
                chk(bus_gnt === 1'b1, "R3 command without grant", bus_gnt, 1);
                chk(!need_drop, "R6 no request gap before burst", need_drop, 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R8 unexpected burst command", mem_cmd_addr, 0);
                end else begin
                    cur = exp_q.pop_front();
                    chk(mem_cmd_write == cur.wr, "R4 burst direction", mem_cmd_write, cur.wr);
                    chk(mem_cmd_addr == cur.addr, "R4 burst address", mem_cmd_addr, cur.addr);
                    chk(mem_cmd_beats == cur.n, "R4 burst length", mem_cmd_beats, cur.n);
                    in_burst = 1;
                    beat     = 0;
                end
            end else if (in_burst && ($urandom % 4 != 0)) begin
                mem_ack <= 1'b1;
                if (cur.wr) chk(mem_wvalid === 1'b1, "R3 write beat valid", mem_wvalid, 1);
                else        mem_rdata <= mem_rd(cur.addr + 4 * beat);
                if (beat_total == err_at) begin
                    mem_berr <= 1'b1;
                    m_busy   = 0;
                    m_err    = 1;
                    in_burst = 0;
                    exp_q.delete();
                end else begin
                    if (cur.wr) begin
                        chk(mem_wdata == mem_rd(cur.from + 4 * beat), "R5 write data",
                            mem_wdata, mem_rd(cur.from + 4 * beat));
                        memw[cur.addr + 4 * beat] = mem_wdata;
                    end
                    beat++;
                    if (beat == int'(cur.n)) begin
                        in_burst  = 0;
                        need_drop = 1;
                        if (cur.wr && exp_q.size() == 0) begin
                            m_busy = 0;
                            m_done = 1;
                        end
                    end
                end
                beat_total++;
            end
        end
    end

    // per-clock comparison of status, interrupt and request
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            if (!m_busy) chk(bus_req == 1'b0, "R7 request while idle", bus_req, 0);
            chk(irq == (m_ie & (m_done | m_err)), "R10 interrupt level", irq, m_ie & (m_done | m_err));
            if (reg_addr == A_STA)
                chk(reg_rdata[2:0] == {m_err, m_done, m_busy}, "R12 status bits",
                    reg_rdata[2:0], {m_err, m_done, m_busy});
        end
    end

    task automatic wr_reg(input logic [4:0] a, input int unsigned d);
        bit started = 0;
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        if (a == A_STA) begin
            if (d[1]) m_done = 0;
            if (d[2]) m_err  = 0;
        end else if (!m_busy) begin
            case (a)
                A_SRC: s_src = d;
                A_DST: s_dst = d;
                A_LEN: s_len = d & 32'hFFFF;
                A_CTL: begin
                    m_ie = d[1];
                    if (d[0]) begin
                        m_done = 0; m_err = 0;
                        if (s_len == 0) m_err = 1;
                        else begin
                            m_busy = 1; started = 1; beat_total = 0;
                            for (int unsigned off = 0; off < s_len; off += 4) begin
                                int unsigned n = (s_len - off >= 4) ? 4 : s_len - off;
                                exp_q.push_back('{0, s_src + 4 * off, n, 0});
                                exp_q.push_back('{1, s_dst + 4 * off, n, s_src + 4 * off});
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
        @(negedge clk);
        reg_we = 0; reg_addr = A_STA;
        if (started) chk(bus_req == 1'b1, "R2 request after go", bus_req, 1);
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = A_STA;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (m_busy && t < 3000) begin @(posedge clk); t++; end
        chk(!m_busy, "R7 transfer did not finish", m_busy, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic copy_check(input int unsigned src, input int unsigned dst, input int unsigned len);
        for (int unsigned i = 0; i < len; i++)
            chk(memw.exists(dst + 4 * i) && memw[dst + 4 * i] == pat(src + 4 * i),
                "R5 destination word", mem_rd(dst + 4 * i), pat(src + 4 * i));
        chk(!memw.exists(dst + 4 * len), "R4 word past end untouched", mem_rd(dst + 4 * len), pat(dst + 4 * len));
    endtask

    task automatic run_copy(input int unsigned src, input int unsigned dst, input int unsigned len, input bit ie);
        wr_reg(A_SRC, src);
        wr_reg(A_DST, dst);
        wr_reg(A_LEN, len);
        wr_reg(A_CTL, {30'd0, ie, 1'b1});
        wait_idle();
        chk(m_done && !m_err, "R7 done after copy", m_done, 1);
        copy_check(src, dst, len);
    endtask

    initial begin
        logic [31:0] v;
        rst_n = 0; reg_we = 0; reg_addr = A_STA; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset values and read-back
        chk(irq == 0 && bus_req == 0, "R1 reset outputs", {irq, bus_req}, 0);
        rd_reg(A_SRC, v); chk(v == 0, "R1 reset source", v, 0);
        rd_reg(A_LEN, v); chk(v == 0, "R1 reset count", v, 0);
        rd_reg(A_STA, v); chk(v == 0, "R1 reset status", v, 0);
        wr_reg(A_SRC, 32'h0000_1000);
        wr_reg(A_DST, 32'h0000_8000);
        wr_reg(A_LEN, 32'h0001_000A);
        wr_reg(A_CTL, 32'h2);
        rd_reg(A_SRC, v); chk(v == 32'h1000, "R1 source read-back", v, 32'h1000);
        rd_reg(A_DST, v); chk(v == 32'h8000, "R1 destination read-back", v, 32'h8000);
        rd_reg(A_LEN, v); chk(v == 32'h000A, "R1 count 16-bit read-back", v, 32'h000A);
        rd_reg(A_CTL, v); chk(v == 32'h2, "R1 control read-back", v, 32'h2);

        // R4 R5 R7 R10: ten words = 4+4+2, interrupt enabled
        run_copy(32'h1000, 32'h8000, 10, 1);
        chk(irq == 1, "R10 interrupt held after done", irq, 1);
        repeat (5) @(negedge clk);
        chk(irq == 1, "R10 interrupt still held", irq, 1);
        wr_reg(A_STA, 32'h2);
        chk(irq == 0, "R12 clear done drops interrupt", irq, 0);

        // other lengths, interrupt disabled for one
        run_copy(32'h2000, 32'h9000, 4, 1);
        wr_reg(A_STA, 32'h2);
        run_copy(32'h2100, 32'h9100, 1, 1);
        run_copy(32'h2200, 32'h9200, 7, 0);
        chk(irq == 0, "R10 no interrupt when disabled", irq, 0);
        wr_reg(A_STA, 32'h2);

        // R9 zero count
        wr_reg(A_LEN, 0);
        wr_reg(A_CTL, 32'h3);
        repeat (4) @(negedge clk);
        chk(m_err && irq == 1 && bus_req == 0, "R9 zero count error", {irq, bus_req}, 2'b10);
        wr_reg(A_STA, 32'h4);
        chk(irq == 0, "R12 clear error drops interrupt", irq, 0);

        // R11 writes while busy are ignored
        wr_reg(A_SRC, 32'h3000);
        wr_reg(A_DST, 32'hA000);
        wr_reg(A_LEN, 12);
        wr_reg(A_CTL, 32'h3);
        wr_reg(A_SRC, 32'h7777);
        wr_reg(A_DST, 32'h6666);
        wr_reg(A_LEN, 3);
        wr_reg(A_CTL, 32'h1);
        wait_idle();
        copy_check(32'h3000, 32'hA000, 12);
        rd_reg(A_SRC, v); chk(v == 32'h3000, "R11 source unchanged", v, 32'h3000);
        rd_reg(A_DST, v); chk(v == 32'hA000, "R11 destination unchanged", v, 32'hA000);
        rd_reg(A_LEN, v); chk(v == 12, "R11 count unchanged", v, 12);
        rd_reg(A_CTL, v); chk(v == 32'h2, "R11 control unchanged", v, 32'h2);

        // R12 accepted go clears done (done left set)
        wr_reg(A_SRC, 32'h3400);
        wr_reg(A_DST, 32'hB000);
        wr_reg(A_LEN, 5);
        wr_reg(A_CTL, 32'h3);
        chk(irq == 0, "R12 go clears done", irq, 0);
        wait_idle();
        copy_check(32'h3400, 32'hB000, 5);
        wr_reg(A_STA, 32'h2);

        // R8 bus error on the second write beat
        err_at = 5;
        wr_reg(A_SRC, 32'h4000);
        wr_reg(A_DST, 32'hC000);
        wr_reg(A_LEN, 12);
        wr_reg(A_CTL, 32'h3);
        wait_idle();
        err_at = -1;
        chk(m_err && !m_done && irq == 1, "R8 error set", irq, 1);
        chk(memw.exists(32'hC000) && !memw.exists(32'hC004), "R8 errored beat not written",
            memw.exists(32'hC004), 0);
        repeat (20) @(negedge clk);
        chk(bus_req == 0, "R8 no activity after error", bus_req, 0);
        wr_reg(A_STA, 32'h4);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule